// File: doc/BRIEF.md
# Banked Address Decoder with Shadow-Write Targeting

This block sits between a 24-bit processor address bus and the memory system. For each access it works out which region serves the access: fast RAM, the slow memory shared with video, ROM, or nothing at all. It also works out the physical bank that is finally used, after two overrides. A vector fetch always lands in the topmost bank. An auxiliary-select input moves bank 0 onto bank 1.

For writes that must also reach video memory, the block raises a shadow-write request and names the slow bank that receives the copy. The auxiliary move is applied first. A write to bank 0 that has been moved therefore lands its copy in the upper slow bank. Two control inputs change the shadow rule. One widens shadowing to every bank, and the copy's bank is then picked from address bit 16 alone. The other masks that bit, so that every copy lands in the lower slow bank.

All results are registered once. They appear, together with a valid flag, on the clock edge after the access is presented.

Top module: `addrdec_top`

## Requirements
- R1: Every output is registered. An access presented with `accValid` high in one cycle produces its results and `outValid` high after the next rising edge. With `accValid` low, `outValid` and `shadowReq` are low after the edge. During reset all outputs are zero.
- R2: Region codes are 0 = fast RAM, 1 = slow shared memory, 2 = ROM and 3 = unmapped. Banks 0x02 to 0x7F report region 0 with `physBank` equal to the address bank. `physAddr` is always `{physBank, addr[15:0]}`.
- R3: With `auxSel` high, bank 0x00 is resolved to bank 0x01 (region 0). Bank 0x01 and every other bank are unaffected by `auxSel`. With `auxSel` low, bank 0x00 stays bank 0x00.
- R4: Banks 0xE0 and 0xE1 report region 1, with `physBank` unchanged.
- R5: With `romBig` low, banks 0xFE and 0xFF are ROM (region 2) and banks 0xF0 to 0xFD are unmapped. With `romBig` high, banks 0xFC to 0xFF are ROM.
- R6: Banks 0x80 to 0xDF and 0xE2 to 0xEF report region 3 with `unmapped` high. `unmapped` is high exactly when the region is 3.
- R7: With `vecPull` high, `physBank` is 0xFF and the region is ROM, whatever the address bank and `auxSel` are. The low 16 address bits pass through unchanged.
- R8: `shadowReq` is high only for a valid access with `writeEn` high and `shadowEn` high. It is never high for a read. When `shadowReq` is low, `shadowBank` is 0x00.
- R9: With `shadowAll` low, only accesses that resolve to bank 0x00 or 0x01 are shadowed. With `shadowAll` high, every resolved bank except 0xE0 and 0xE1 is shadowed.
- R10: With `blockA16` low, `shadowBank` is 0xE0 when bit 0 of the resolved bank is 0, and 0xE1 when it is 1. A write to bank 0x00 that is moved by `auxSel` therefore targets 0xE1.
- R11: With `blockA16` high, every shadow write targets 0xE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| addr | input | 24 | Processor address; bank in bits 23:16 |
| writeEn | input | 1 | High for a write cycle |
| vecPull | input | 1 | Vector fetch; forces the top bank |
| auxSel | input | 1 | Moves bank 0 onto bank 1 |
| romBig | input | 1 | 0 = two ROM banks, 1 = four ROM banks |
| shadowAll | input | 1 | Shadow in every bank, target picked by bit 16 |
| blockA16 | input | 1 | Ignore bit 16 for shadowing; target the lower slow bank |
| shadowEn | input | 1 | Per-access shadow permission |
| outValid | output | 1 | Registered results are valid |
| region | output | 2 | 0 fast, 1 slow, 2 ROM, 3 unmapped |
| physBank | output | 8 | Resolved physical bank |
| physAddr | output | 24 | Resolved physical address |
| unmapped | output | 1 | Access hits no populated memory |
| shadowReq | output | 1 | Mirror this write into slow memory |
| shadowBank | output | 8 | Slow bank that receives the mirror write |

## Verification
The bench builds the block with its default parameters: an 8-bit bank field, a 16-bit offset, a 16-bank ROM region holding 2 or 4 populated banks, two slow banks at 0xE0, and 128 fast banks. With these values every region edge can be reached with ordinary 24-bit addresses: 0x01/0x02, 0x7F/0x80, 0xDF/0xE0, 0xE1/0xE2, 0xEF/0xF0, 0xFB/0xFC and 0xFD/0xFE. The bench also covers the interactions of the auxiliary move, the vector fetch and the two shadow controls at those banks.

// File: rtl/addrdec_pkg.sv
package addrdec_pkg;

  typedef enum logic [1:0] {
    REG_FAST = 2'd0,
    REG_SLOW = 2'd1,
    REG_ROM  = 2'd2,
    REG_NONE = 2'd3
  } regionT;

  // Strobes from control to datapath
  typedef struct packed {
    logic   valid;
    logic   vecForce;
    logic   auxRedirect;
    regionT region;
    logic   shadowFire;
    logic   shadowHigh;
  } ctrlStrobesT;

endpackage

// File: rtl/addrdec_ctrl.sv
module addrdec_ctrl
  import addrdec_pkg::*;
#(
  parameter int BANK_W           = 8,
  parameter int ROM_REGION_BANKS = 16,
  parameter int ROM_SMALL_BANKS  = 2,
  parameter int ROM_BIG_BANKS    = 4,
  parameter int SLOW_BASE        = 224,
  parameter int SLOW_BANKS       = 2,
  parameter int FAST_BANKS       = 128,
  parameter int LOW_BANKS        = 2
) (
  input  logic              accValid,
  input  logic [BANK_W-1:0] bankIn,
  input  logic              writeEn,
  input  logic              vecPull,
  input  logic              auxSel,
  input  logic              romBig,
  input  logic              shadowAll,
  input  logic              blockA16,
  input  logic              shadowEn,
  output ctrlStrobesT       strobes
);

  localparam int NUM_BANKS  = 1 << BANK_W;
  localparam int ROM_BASE   = NUM_BANKS - ROM_REGION_BANKS;
  localparam int SMALL_BASE = NUM_BANKS - ROM_SMALL_BANKS;
  localparam int BIG_BASE   = NUM_BANKS - ROM_BIG_BANKS;
  localparam int SLOW_END   = SLOW_BASE + SLOW_BANKS;

  logic [BANK_W-1:0] vecBank;
  logic [BANK_W-1:0] resBank;
  logic              redirect;
  int                resIdx;
  int                romStart;
  logic              isSlow;
  logic              inLow;
  regionT            regionNext;

  always_comb begin
    vecBank  = vecPull ? '1 : bankIn;
    redirect = auxSel && (vecBank == '0);
    resBank  = redirect ? BANK_W'(1) : vecBank;
    resIdx   = int'(resBank);
    romStart = romBig ? BIG_BASE : SMALL_BASE;
    isSlow   = (resIdx >= SLOW_BASE) && (resIdx < SLOW_END);
    inLow    = resIdx < LOW_BANKS;
  end

  always_comb begin
    if (resIdx >= ROM_BASE) begin
      regionNext = (resIdx >= romStart) ? REG_ROM : REG_NONE;
    end else if (isSlow) begin
      regionNext = REG_SLOW;
    end else if (resIdx < FAST_BANKS) begin
      regionNext = REG_FAST;
    end else begin
      regionNext = REG_NONE;
    end
  end

  always_comb begin
    strobes.valid       = accValid;
    strobes.vecForce    = vecPull;
    strobes.auxRedirect = redirect;
    strobes.region      = regionNext;
    strobes.shadowFire  = accValid && writeEn && shadowEn &&
                          (shadowAll ? !isSlow : inLow);
    strobes.shadowHigh  = !blockA16 && resBank[0];
  end

endmodule

// File: rtl/addrdec_dpath.sv
module addrdec_dpath
  import addrdec_pkg::*;
#(
  parameter int BANK_W    = 8,
  parameter int OFFS_W    = 16,
  parameter int SLOW_BASE = 224
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [BANK_W+OFFS_W-1:0] addr,
  input  ctrlStrobesT              strobes,
  output logic                     outValid,
  output logic [1:0]               region,
  output logic [BANK_W-1:0]        physBank,
  output logic [BANK_W+OFFS_W-1:0] physAddr,
  output logic                     unmapped,
  output logic                     shadowReq,
  output logic [BANK_W-1:0]        shadowBank
);

  localparam logic [BANK_W-1:0] SLOW_LOW = BANK_W'(SLOW_BASE);

  logic [BANK_W-1:0] bankIn;
  logic [BANK_W-1:0] bankNext;
  logic [BANK_W-1:0] shadowNext;

  assign bankIn = addr[BANK_W+OFFS_W-1:OFFS_W];

  always_comb begin
    if (strobes.vecForce) begin
      bankNext = '1;
    end else if (strobes.auxRedirect) begin
      bankNext = BANK_W'(1);
    end else begin
      bankNext = bankIn;
    end
    shadowNext = strobes.shadowFire ?
                 (SLOW_LOW | BANK_W'(strobes.shadowHigh)) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      region     <= 2'd0;
      physBank   <= '0;
      physAddr   <= '0;
      unmapped   <= 1'b0;
      shadowReq  <= 1'b0;
      shadowBank <= '0;
    end else begin
      outValid   <= strobes.valid;
      region     <= strobes.region;
      physBank   <= bankNext;
      physAddr   <= {bankNext, addr[OFFS_W-1:0]};
      unmapped   <= strobes.region == REG_NONE;
      shadowReq  <= strobes.shadowFire;
      shadowBank <= shadowNext;
    end
  end

endmodule

// File: rtl/addrdec_top.sv
module addrdec_top
  import addrdec_pkg::*;
#(
  parameter int BANK_W           = 8,
  parameter int OFFS_W           = 16,
  parameter int ROM_REGION_BANKS = 16,
  parameter int ROM_SMALL_BANKS  = 2,
  parameter int ROM_BIG_BANKS    = 4,
  parameter int SLOW_BASE        = 224,
  parameter int SLOW_BANKS       = 2,
  parameter int FAST_BANKS       = 128,
  parameter int LOW_BANKS        = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     accValid,
  input  logic [BANK_W+OFFS_W-1:0] addr,
  input  logic                     writeEn,
  input  logic                     vecPull,
  input  logic                     auxSel,
  input  logic                     romBig,
  input  logic                     shadowAll,
  input  logic                     blockA16,
  input  logic                     shadowEn,
  output logic                     outValid,
  output logic [1:0]               region,
  output logic [BANK_W-1:0]        physBank,
  output logic [BANK_W+OFFS_W-1:0] physAddr,
  output logic                     unmapped,
  output logic                     shadowReq,
  output logic [BANK_W-1:0]        shadowBank
);

  ctrlStrobesT strobes;

  addrdec_ctrl #(
    .BANK_W(BANK_W), .ROM_REGION_BANKS(ROM_REGION_BANKS),
    .ROM_SMALL_BANKS(ROM_SMALL_BANKS), .ROM_BIG_BANKS(ROM_BIG_BANKS),
    .SLOW_BASE(SLOW_BASE), .SLOW_BANKS(SLOW_BANKS),
    .FAST_BANKS(FAST_BANKS), .LOW_BANKS(LOW_BANKS)
  ) i_ctrl (
    .accValid (accValid),
    .bankIn   (addr[BANK_W+OFFS_W-1:OFFS_W]),
    .writeEn  (writeEn),
    .vecPull  (vecPull),
    .auxSel   (auxSel),
    .romBig   (romBig),
    .shadowAll(shadowAll),
    .blockA16 (blockA16),
    .shadowEn (shadowEn),
    .strobes  (strobes)
  );

  addrdec_dpath #(
    .BANK_W(BANK_W), .OFFS_W(OFFS_W), .SLOW_BASE(SLOW_BASE)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .strobes   (strobes),
    .outValid  (outValid),
    .region    (region),
    .physBank  (physBank),
    .physAddr  (physAddr),
    .unmapped  (unmapped),
    .shadowReq (shadowReq),
    .shadowBank(shadowBank)
  );

endmodule

// File: rtl/addrdec_chk.sv
module addrdec_chk #(
  parameter int BANK_W = 8,
  parameter int OFFS_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     accValid,
  input logic [BANK_W+OFFS_W-1:0] addr,
  input logic                     writeEn,
  input logic                     vecPull,
  input logic                     auxSel,
  input logic                     romBig,
  input logic                     shadowAll,
  input logic                     blockA16,
  input logic                     shadowEn,
  input logic                     outValid,
  input logic [1:0]               region,
  input logic [BANK_W-1:0]        physBank,
  input logic [BANK_W+OFFS_W-1:0] physAddr,
  input logic                     unmapped,
  input logic                     shadowReq,
  input logic [BANK_W-1:0]        shadowBank
);

  localparam logic [BANK_W-1:0] SLOW_LOW = BANK_W'(224);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(accValid)));

  assert_idle_no_shadow_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !shadowReq);

  assert_vector_top_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(vecPull)) |-> (physBank == '1 && region == 2'd2));

  assert_aux_move_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(auxSel) && !$past(vecPull) &&
     $past(addr[BANK_W+OFFS_W-1:OFFS_W]) == '0) |-> (physBank == BANK_W'(1)));

  assert_read_no_shadow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(writeEn)) |-> !shadowReq);

  assert_mask_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (shadowReq && $past(blockA16)) |-> (shadowBank == SLOW_LOW));

  assert_unmapped_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (unmapped == (region == 2'd3)));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (physAddr[OFFS_W-1:0] == $past(addr[OFFS_W-1:0]) &&
                  physAddr[BANK_W+OFFS_W-1:OFFS_W] == physBank));

endmodule

bind addrdec_top addrdec_chk #(.BANK_W(BANK_W), .OFFS_W(OFFS_W)) i_chk (.*);

// File: tb/test_addrdec_top.sv
module test_addrdec_top;

  typedef struct {
    logic [1:0]  region;
    logic [7:0]  physBank;
    logic [23:0] physAddr;
    logic        unmapped;
    logic        shadowReq;
    logic [7:0]  shadowBank;
    string       tag;
  } expT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [23:0] addr = '0;
  logic        writeEn = 1'b0, vecPull = 1'b0, auxSel = 1'b0, romBig = 1'b0;
  logic        shadowAll = 1'b0, blockA16 = 1'b0, shadowEn = 1'b0;
  logic        outValid, unmapped, shadowReq;
  logic [1:0]  region;
  logic [7:0]  physBank, shadowBank;
  logic [23:0] physAddr;

  int   testsRun = 0;
  int   testsFailed = 0;
  expT  expQ[$];
  logic driving = 1'b0;

  always #10 clk = ~clk;

  addrdec_top i_addrdec_top (
    .clk(clk), .rstN(rstN), .accValid(accValid), .addr(addr),
    .writeEn(writeEn), .vecPull(vecPull), .auxSel(auxSel), .romBig(romBig),
    .shadowAll(shadowAll), .blockA16(blockA16), .shadowEn(shadowEn),
    .outValid(outValid), .region(region), .physBank(physBank),
    .physAddr(physAddr), .unmapped(unmapped), .shadowReq(shadowReq),
    .shadowBank(shadowBank)
  );

  function automatic expT model(logic [23:0] a, logic we, logic vp,
                                logic aux, logic big, logic sAll,
                                logic blk, logic sEn, string tag);
    expT  e;
    logic [7:0] b;
    logic slow;
    b = vp ? 8'hFF : a[23:16];
    if (aux && b == 8'h00) b = 8'h01;
    slow = (b == 8'hE0) || (b == 8'hE1);
    if (b >= 8'hF0)      e.region = (b >= (big ? 8'hFC : 8'hFE)) ? 2'd2 : 2'd3;
    else if (slow)       e.region = 2'd1;
    else if (b <= 8'h7F) e.region = 2'd0;
    else                 e.region = 2'd3;
    e.physBank  = b;
    e.physAddr  = {b, a[15:0]};
    e.unmapped  = (e.region == 2'd3);
    e.shadowReq = we && sEn && (sAll ? !slow : (b <= 8'h01));
    e.shadowBank = !e.shadowReq ? 8'h00 : ((blk || !b[0]) ? 8'hE0 : 8'hE1);
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(logic [23:0] a, logic we, logic vp, logic aux,
                       logic big, logic sAll, logic blk, logic sEn,
                       string tag);
    @(negedge clk);
    accValid = 1'b1; addr = a; writeEn = we; vecPull = vp; auxSel = aux;
    romBig = big; shadowAll = sAll; blockA16 = blk; shadowEn = sEn;
    expQ.push_back(model(a, we, vp, aux, big, sAll, blk, sEn, tag));
  endtask

  task automatic check(bit ok, string tag, string what, string act, string exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s actual=%s expected=%s", tag, what, act, exp);
    end
  endtask

  // Monitor: outputs settle after posedge, sampled at negedge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      expT e;
      if (expQ.size() == 0) begin
        check(1'b0, "R1", "unexpected outValid", "1", "0");
      end else begin
        e = expQ.pop_front();
        check(region == e.region, e.tag, "region",
              $sformatf("%0d", region), $sformatf("%0d", e.region));
        check(physAddr == e.physAddr && physBank == e.physBank, e.tag, "physAddr",
              $sformatf("%h", physAddr), $sformatf("%h", e.physAddr));
        check(unmapped == e.unmapped, e.tag, "unmapped",
              $sformatf("%b", unmapped), $sformatf("%b", e.unmapped));
        check(shadowReq == e.shadowReq && shadowBank == e.shadowBank, e.tag,
              "shadow", $sformatf("%b/%h", shadowReq, shadowBank),
              $sformatf("%b/%h", e.shadowReq, e.shadowBank));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", "hung", "done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!outValid && !shadowReq && physAddr == 0 && region == 0, "R1",
          "reset state", $sformatf("%b%b%h", outValid, shadowReq, physAddr), "00000000");
    rstN = 1'b1;
    @(negedge clk);
    check(!outValid, "R1", "idle outValid", $sformatf("%b", outValid), "0");

    // R2 fast banks and edges
    drive(24'h02_1234, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(24'h7F_FFFF, 0, 0, 0, 0, 0, 0, 0, "R2");
    drive(24'h40_0001, 1, 0, 1, 0, 0, 0, 1, "R2");
    // R3 auxiliary move
    drive(24'h00_ABCD, 0, 0, 1, 0, 0, 0, 0, "R3");
    drive(24'h00_ABCD, 0, 0, 0, 0, 0, 0, 0, "R3");
    drive(24'h01_0042, 0, 0, 1, 0, 0, 0, 0, "R3");
    drive(24'hE0_0042, 0, 0, 1, 0, 0, 0, 0, "R3");
    // R4 slow banks
    drive(24'hE0_2000, 0, 0, 0, 0, 0, 0, 0, "R4");
    drive(24'hE1_2000, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R5 ROM size
    drive(24'hFD_0000, 0, 0, 0, 0, 0, 0, 0, "R5");
    drive(24'hFE_0000, 0, 0, 0, 0, 0, 0, 0, "R5");
    drive(24'hFC_0000, 0, 0, 0, 1, 0, 0, 0, "R5");
    drive(24'hFB_0000, 0, 0, 0, 1, 0, 0, 0, "R5");
    drive(24'hF0_0000, 0, 0, 0, 1, 0, 0, 0, "R5");
    // R6 unpopulated banks
    drive(24'h80_0000, 0, 0, 0, 0, 0, 0, 0, "R6");
    drive(24'hDF_FFFF, 0, 0, 0, 0, 0, 0, 0, "R6");
    drive(24'hE2_0000, 0, 0, 0, 0, 0, 0, 0, "R6");
    drive(24'hEF_0000, 0, 0, 0, 0, 0, 0, 0, "R6");
    // R7 vector pull
    drive(24'h00_FFFC, 0, 1, 1, 0, 0, 0, 0, "R7");
    drive(24'h85_FFEA, 0, 1, 0, 1, 0, 0, 0, "R7");
    // R8 shadow gating
    drive(24'h00_0400, 0, 0, 0, 0, 0, 0, 1, "R8");
    drive(24'h00_0400, 1, 0, 0, 0, 0, 0, 0, "R8");
    drive(24'h00_0400, 1, 0, 0, 0, 0, 0, 1, "R8");
    // R9 shadow scope
    drive(24'h02_0400, 1, 0, 0, 0, 0, 0, 1, "R9");
    drive(24'h03_0400, 1, 0, 0, 0, 1, 0, 1, "R9");
    drive(24'h82_0400, 1, 0, 0, 0, 1, 0, 1, "R9");
    drive(24'hE1_0400, 1, 0, 0, 0, 1, 0, 1, "R9");
    drive(24'hE0_0400, 1, 0, 0, 0, 0, 0, 1, "R9");
    // R10 target by resolved bit 16
    drive(24'h00_2000, 1, 0, 1, 0, 0, 0, 1, "R10");
    drive(24'h01_2000, 1, 0, 0, 0, 0, 0, 1, "R10");
    drive(24'h7E_2000, 1, 0, 0, 0, 1, 0, 1, "R10");
    // R11 masked bit 16
    drive(24'h01_2000, 1, 0, 0, 0, 0, 1, 1, "R11");
    drive(24'h00_2000, 1, 0, 1, 0, 0, 1, 1, "R11");
    drive(24'h23_2000, 1, 0, 0, 0, 1, 1, 1, "R11");

    @(negedge clk);
    accValid = 1'b0; writeEn = 1'b1; shadowEn = 1'b1; addr = 24'h00_0000;
    @(negedge clk);
    @(negedge clk);
    check(!outValid && !shadowReq, "R1", "no result without accValid",
          $sformatf("%b%b", outValid, shadowReq), "00");
    check(expQ.size() == 0, "R1", "pending results",
          $sformatf("%0d", expQ.size()), "0");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule